// File: doc/BRIEF.md
# Byte-Parallel Frame-Synchronous Scrambler

This block whitens a byte-wide line stream so that the receiver's clock recovery sees enough transitions. A seven-stage shift-register generator built on the polynomial x^7+x^6+1 produces eight keystream bits per accepted byte, and these bits are XORed onto the byte. Since XOR with the same keystream undoes itself, one instance placed before the line scrambles and a second instance placed after the line descrambles. One byte goes in and one byte comes out, so the line rate does not change.

A frame-start strobe reloads the generator with its all-ones seed, which keeps the two ends in step. A bypass flag sent with each byte marks overhead bytes that must cross the line untouched. Those bytes still use up their eight keystream bits, so the keystream stays aligned to byte position within the frame. Finding overhead and framing the byte boundary are jobs for the logic around this block.

Top module: `frame_scrambler`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_data` are both 0 after that edge. The generator leaves reset holding its all-ones seed, so the first valid non-bypassed byte after reset is XORed with 0xFE even when no frame start is given.
- R2: The keystream comes from a 7-bit generator with polynomial x^7+x^6+1, seeded with all ones. Bit 7 of the data byte receives the earliest keystream bit. The first three keystream bytes after a seed are 0xFE, 0x04 and 0x18, and the fourth is 0x51.
- R3: For a valid byte with `in_bypass` low, `out_data` equals `in_data` XOR the current keystream byte.
- R4: For a valid byte with `in_bypass` high, `out_data` equals `in_data`. The generator still advances by eight bits, so the next scrambled byte uses the following keystream byte.
- R5: A cycle with `in_valid` low and `in_frame_start` low leaves the generator unchanged, and it gives `out_valid` low one cycle later.
- R6: `in_frame_start` reloads the all-ones seed. When it comes with a valid byte, that byte uses keystream 0xFE. When it comes without a valid byte, the next valid byte uses 0xFE.
- R7: The keystream repeats every 127 bytes: byte n and byte n+127 after a seed get the same keystream byte.
- R8: Latency is one clock: `out_valid` follows `in_valid` by one cycle, and `out_data` changes only for valid bytes.
- R9: Feeding the scrambled frame back in, starting with a frame start, gives back the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Byte to scramble or descramble |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_frame_start | input | 1 | Reload the generator seed (first byte of a frame) |
| in_bypass | input | 1 | Pass this byte unchanged; the keystream still advances |
| out_data | output | 8 | Result byte, registered |
| out_valid | output | 1 | `out_data` is new this cycle |

## Verification
Four things are checked on every cycle. First, the generator state never becomes all zeros. Second, it holds when nothing is accepted, and a reload without a byte leaves the seed in place. Third, each output byte equals the input byte, either with the keystream XORed on or untouched under bypass. Fourth, valid follows one cycle behind. Other behaviour needs the bench's scenarios: that the keystream is the right sequence in the right bit order, that bypassed bytes still use up keystream, that it repeats after 127 bytes, and that scrambling twice gives the data back.

// File: rtl/scr_pkg.sv
// Package: shared sizing for the frame scrambler.
// Assumes: the generator is a single-feedback shift register whose two
// taps are its top stage and stage TAP_LO (1-based).
package scr_pkg;
    localparam int unsigned BYTE_W  = 8;   // data and keystream width per beat
    localparam int unsigned GEN_W   = 7;   // generator degree
    localparam int unsigned GEN_TAP = 6;   // lower tap of x^GEN_W + x^GEN_TAP + 1
endpackage

// File: rtl/scr_keygen.sv
// Module: scr_keygen
// Produces KS_W keystream bits per accepted beat from an LFSR with
// polynomial x^LFSR_W + x^TAP_LO + 1. The earliest bit goes to ks[KS_W-1].
// Assumes: reload and step_en are synchronous; reload with step_en
// means the beat uses keystream taken straight from the seed.
module scr_keygen #(
    parameter int unsigned LFSR_W = scr_pkg::GEN_W,
    parameter int unsigned TAP_LO = scr_pkg::GEN_TAP,
    parameter int unsigned KS_W   = scr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              reload,
    output logic [KS_W-1:0]   ks
);
    localparam logic [LFSR_W-1:0] SEED = '1;

    logic [LFSR_W-1:0] q_r;
    logic [LFSR_W-1:0] base;
    logic [LFSR_W-1:0] adv;

    // Purpose: choose the starting state and walk KS_W single-bit steps.
    always_comb begin
        logic [LFSR_W-1:0] t;
        base = reload ? SEED : q_r;
        t    = base;
        ks   = '0;
        for (int i = 0; i < KS_W; i++) begin
            ks[KS_W-1-i] = t[LFSR_W-1];
            t = {t[LFSR_W-2:0], t[LFSR_W-1] ^ t[TAP_LO-1]};
        end
        adv = t;
    end

    // Purpose: hold the generator state; seed on reset or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= SEED;
        else if (step_en) q_r <= adv;
        else if (reload)  q_r <= SEED;
    end

    // R2: the all-zero lock-up state must never be reached.
    a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q_r != '0);
    // R5: with nothing accepted and no reload, the state holds.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !reload) |=> $stable(q_r));
    // R6: a reload without a byte leaves the seed in place.
    a_r6_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !step_en) |=> (q_r == SEED));
endmodule

// File: rtl/scr_mixer.sv
// Module: scr_mixer
// Registers one result byte per valid beat: data XOR keystream, or data
// unchanged when bypass is set. The output holds while no beat is valid.
// Assumes: ks is valid in the same cycle as the beat.
module scr_mixer #(
    parameter int unsigned DATA_W = scr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              v_in,
    input  logic              byp_in,
    input  logic [DATA_W-1:0] ks,
    output logic [DATA_W-1:0] d_out,
    output logic              v_out
);
    // Purpose: one-cycle output stage with valid carried alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_out <= '0;
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= byp_in ? d_in : (d_in ^ ks);
        end
    end

    // R3: a scrambled byte is the input with the keystream XORed on.
    a_r3_xor_result: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && !byp_in) |=> (d_out == ($past(d_in) ^ $past(ks))));
    // R4: a bypassed byte passes unchanged.
    a_r4_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && byp_in) |=> (d_out == $past(d_in)));
    // R8: valid follows one cycle behind, and the data holds when idle.
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> (!v_out && $stable(d_out)));
endmodule

// File: rtl/frame_scrambler.sv
// Module: frame_scrambler (top)
// Byte-parallel frame-synchronous scrambler/descrambler. The generator
// advances on every valid byte, bypassed or not, and reloads on frame start.
// Assumes: byte alignment and overhead marking happen upstream.
module frame_scrambler #(
    parameter int unsigned DATA_W = scr_pkg::BYTE_W,
    parameter int unsigned GEN_W  = scr_pkg::GEN_W,
    parameter int unsigned TAP_LO = scr_pkg::GEN_TAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_frame_start,
    input  logic              in_bypass,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    logic [DATA_W-1:0] ks_byte;

    // Keystream source, one step of DATA_W bits per valid byte.
    scr_keygen #(.LFSR_W(GEN_W), .TAP_LO(TAP_LO), .KS_W(DATA_W)) u_keygen (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (in_valid),
        .reload  (in_frame_start),
        .ks      (ks_byte)
    );

    // Output stage applying the keystream or the bypass.
    scr_mixer #(.DATA_W(DATA_W)) u_mixer (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (in_data),
        .v_in   (in_valid),
        .byp_in (in_bypass),
        .ks     (ks_byte),
        .d_out  (out_data),
        .v_out  (out_valid)
    );

    // R1: reset clears both outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));
endmodule

// File: tb/frame_scrambler_tb.sv
module frame_scrambler_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_frame_start = 1'b0;
    logic       in_bypass = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;

    int checks = 0;
    int errors = 0;
    logic [6:0] ref_q = 7'h7F;

    always #2.5 clk = ~clk;  // 200 MHz

    frame_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_frame_start(in_frame_start), .in_bypass(in_bypass),
        .out_data(out_data), .out_valid(out_valid)
    );

    // Row layout: {start, valid, bypass, data[7:0], expected[7:0]}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 8'h00, 8'hFE},  // R6 R2 first keystream byte
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h04},  // R2 second byte
        {1'b0, 1'b0, 1'b0, 8'hAA, 8'h00},  // R5 idle, generator holds
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'hE7},  // R3 0xFF ^ 0x18
        {1'b1, 1'b1, 1'b1, 8'h5A, 8'h5A},  // R4 bypass at frame start
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h04},  // R4 bypass still advanced
        {1'b0, 1'b1, 1'b1, 8'hC3, 8'hC3},  // R4 bypass mid-frame
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h51},  // R2 R4 fourth byte
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h00},  // R6 reload without a byte
        {1'b0, 1'b1, 1'b0, 8'h3C, 8'hC2}   // R6 0x3C ^ 0xFE
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Bit-serial reference: one keystream byte, earliest bit on bit 7.
    task automatic model(input logic s, input logic v, output logic [7:0] k);
        k = '0;
        if (s) ref_q = 7'h7F;
        if (v) begin
            for (int i = 0; i < 8; i++) begin
                k[7-i] = ref_q[6];
                ref_q = {ref_q[5:0], ref_q[6] ^ ref_q[5]};
            end
        end
    endtask

    // Drive one beat at the falling edge, sample after the next rising edge.
    task automatic beat(input logic s, input logic v, input logic b,
                        input logic [7:0] d, output logic [7:0] got, output logic gv);
        in_frame_start = s; in_valid = v; in_bypass = b; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_frame_start = 1'b0; in_valid = 1'b0; in_bypass = 1'b0;
        got = out_data; gv = out_valid;
    endtask

    initial begin
        logic [7:0] got, k;
        logic gv;
        logic [7:0] cap [20];

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid in reset", {7'd0, out_valid}, 8'h00);
        chk("R1 out_data in reset", out_data, 8'h00);
        rst_n = 1'b1;
        beat(1'b0, 1'b1, 1'b0, 8'h00, got, gv);
        chk("R1 seed after reset", got, 8'hFE);
        chk("R8 valid after one cycle", {7'd0, gv}, 8'h01);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int r = 0; r < NV; r++) begin
            logic [18:0] e;
            e = VEC[r];
            beat(e[18], e[17], e[16], e[15:8], got, gv);
            chk($sformatf("R8 table row %0d valid", r), {7'd0, gv}, {7'd0, e[17]});
            if (e[17]) chk($sformatf("R2/R3/R4/R6 table row %0d data", r), got, e[7:0]);
        end

        // R7: period of 127 bytes against the bit-serial model
        for (int n = 0; n < 130; n++) begin
            model(n == 0, 1'b1, k);
            beat(n == 0, 1'b1, 1'b0, 8'h00, got, gv);
            if (n < 3 || n > 125) chk($sformatf("R7 byte %0d", n), got, k);
            if (n == 127) chk("R7 repeat of first byte", got, 8'hFE);
            if (n == 128) chk("R7 repeat of second byte", got, 8'h04);
        end

        // R9: scramble a frame, then descramble it
        for (int n = 0; n < 20; n++) begin
            beat(n == 0, 1'b1, (n == 5), 8'(n * 37 + 5), got, gv);
            cap[n] = got;
        end
        for (int n = 0; n < 20; n++) begin
            beat(n == 0, 1'b1, (n == 5), cap[n], got, gv);
            chk($sformatf("R9 round trip byte %0d", n), got, 8'(n * 37 + 5));
        end

        // R1: reset in the middle of a stream
        in_valid = 1'b1; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 mid-stream reset valid", {7'd0, out_valid}, 8'h00);
        rst_n = 1'b1;
        beat(1'b0, 1'b1, 1'b0, 8'h0F, got, gv);
        chk("R1 reseed after mid-stream reset", got, 8'hF1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule